// File: doc/BRIEF.md
# Wide Register Write Collector

This block is the register-access front end of a device whose control registers are 128 bits wide and whose translation table holds 64-bit entries. The host bus moves only 32 or 64 bits per access. Lower pieces of a wide register are parked in a collection buffer. The whole register changes in a single cycle when its top piece arrives, so downstream logic never sees half of an old value joined to half of a new one. Reads are kept consistent the same way. A read of the lowest piece returns live data and also freezes a copy of the whole register in a shadow. Reads of the higher pieces come from that copy.

A few pointer-style registers take a lone dword write that lands at once. Such a write may fall between the pieces of a wide write without harming it. Registers repeat in page blocks of 0x2000 bytes. The table region starts at a parameterised base. The host side is a single-cycle request port with a response one cycle later. Requests are always accepted, so there is no ready signal. Responses cannot be back-pressured, and the host must take `rsp_valid` in the cycle it appears. Each cycle carries at most one request, either a read or a write. Address bits [1:0] are ignored.

Top module: `wide_reg_collector`

## Requirements
- R1: A 32-bit write to offset 0, 4 or 8 of a wide register only fills the collection buffer, and the register is left unchanged. A 32-bit write to offset 12 loads all 128 bits (offset 12 data in bits 127:96, the buffered dwords below it) on the same clock edge.
- R2: A 64-bit write to offset 0 of a wide register is buffered. A 64-bit write to offset 8 commits, with its data in bits 127:64. A 64-bit access at offset 4 or 12 has no effect, and a read there returns zero.
- R3: A read at offset 0 returns the live value (bits 31:0 for 32-bit, bits 63:0 for 64-bit) and copies the full register into the shadow. A 32-bit read at offset 4, 8 or 12 returns shadow dword 1, 2 or 3. A 64-bit read at offset 8 returns shadow bits 127:64. A 32-bit result sits in bits 31:0 of `rsp_data`, and the upper half is zero.
- R4: Each page has three direct registers, at page offsets 0x100, 0x110 and 0x120. A 32-bit write updates one on the clock edge of the write, and a read returns its live value.
- R5: A direct-register write that lands between the pieces of a wide write leaves the buffered pieces, the pending commit and every wide register unchanged.
- R6: Table entry n sits at TBL_BASE + 8·n. A 64-bit write at entry offset 0 replaces the whole entry. A 32-bit write at offset 0 is buffered, and a 32-bit write at offset 4 commits {new, buffered}.
- R7: A table read at entry offset 0 copies the entry into a table shadow. A 32-bit read at offset 4 returns the upper half of that copy.
- R8: The collector remembers which register or entry its first piece belonged to. If the commit piece targets a different one, or nothing is pending, only the new piece is merged over the target's current contents, the pending state clears, and `collect_err` rises. `collect_err` stays high until reset.
- R9: Page p occupies addresses p·0x2000 to p·0x2000+0x1FFF. Wide register i sits at page offset 16·i, and every page has its own registers.
- R10: A read of an unmapped address returns zero. A write to one changes no register.
- R11: `rsp_valid` is high exactly in the cycle after a read request and at no other time.
- R12: After reset every register, table entry, buffer and shadow is zero, no commit is pending and `collect_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | AW | Byte address |
| req_wdata | input | 64 | Write data; 32-bit writes use bits 31:0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 64 | Read data |
| collect_err | output | 1 | Sticky commit-mismatch flag |
| wide_regs_o | output | NPAGE·NWREG·128 | All wide registers, register p·NWREG+i at bits [(p·NWREG+i)·128 +: 128] |
| dir_regs_o | output | NPAGE·3·32 | Direct registers, register p·3+k at bits [(p·3+k)·32 +: 32] |

## Verification
The assertions check the rules that must hold on every cycle:
- the response comes exactly one cycle after a read;
- a lower-piece wide write and a direct write never move a wide register;
- registers change only after a write request;
- the error flag never drops.

Only the bench scenarios can show the data itself. These scenarios cover:
- the committed value assembled from the right pieces;
- the shadow returning an old value after a newer commit;
- an interleaved direct write leaving the commit intact;
- the merge taken on a mismatched commit;
- page separation, unmapped reads and table snapshots.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  typedef enum logic [1:0] {TGT_NONE, TGT_WIDE, TGT_DIRECT, TGT_TABLE} tgt_e;
  localparam int PAGE_SHIFT = 13;
  localparam int WIDE_W     = 128;
  localparam int ENTRY_W    = 64;
  localparam int DWORD_W    = 32;
  localparam int NDIRECT    = 3;
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
  import wrc_pkg::*;
#(
  parameter int AW       = 20,
  parameter int NPAGE    = 2,
  parameter int NWREG    = 4,
  parameter int NTBL     = 16,
  parameter int TBL_BASE = 'h8000,
  parameter int DSLOT    = 'h10,
  parameter int PGW      = 1,
  parameter int IW       = 2,
  parameter int TW       = 4
) (
  input  logic [AW-1:0]  addr,
  output tgt_e           tgt,
  output logic [PGW-1:0] page,
  output logic [IW-1:0]  widx,
  output logic [1:0]     didx,
  output logic [TW-1:0]  tidx,
  output logic [1:0]     sub
);
  logic [AW-1:0] toff;
  logic [8:0]    slot;
  logic [8:0]    dslot_rel;

  always_comb begin
    toff      = addr - AW'(TBL_BASE);
    slot      = addr[PAGE_SHIFT-1:4];
    dslot_rel = slot - 9'(DSLOT);
    tgt       = TGT_NONE;
    page      = addr[PAGE_SHIFT +: PGW];
    widx      = slot[IW-1:0];
    didx      = dslot_rel[1:0];
    tidx      = toff[3 +: TW];
    sub       = addr[3:2];
    if (addr < AW'(NPAGE * (1 << PAGE_SHIFT))) begin
      if (slot < 9'(NWREG))
        tgt = TGT_WIDE;
      else if (slot >= 9'(DSLOT) && slot < 9'(DSLOT + NDIRECT) && addr[3:2] == 2'd0)
        tgt = TGT_DIRECT;
    end else if (addr >= AW'(TBL_BASE) && toff < AW'(NTBL * 8)) begin
      tgt = TGT_TABLE;
      sub = {1'b0, addr[2]};
    end
  end
endmodule

// File: rtl/wrc_wide_bank.sv
module wrc_wide_bank
  import wrc_pkg::*;
#(
  parameter int NREG = 8,
  parameter int FW   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic                   rd,
  input  logic                   size64,
  input  logic [FW-1:0]          fi,
  input  logic [1:0]             sub,
  input  logic [63:0]            wdata,
  output logic [NREG*WIDE_W-1:0] regs_o,
  output logic [63:0]            rdata,
  output logic                   err_o
);
  logic [WIDE_W-1:0]  reg_q [NREG];
  logic [DWORD_W-1:0] buf_q [3];
  logic               pend_q;
  logic [FW-1:0]      tag_q;
  logic [WIDE_W-1:0]  shadow_q;
  logic               err_q;

  logic [WIDE_W-1:0] cur;
  logic [WIDE_W-1:0] commit_val;
  logic hit, is_piece, is_commit;

  always_comb begin
    cur       = reg_q[fi];
    hit       = pend_q && (tag_q == fi);
    is_piece  = size64 ? (sub == 2'd0) : (sub != 2'd3);
    is_commit = size64 ? (sub == 2'd2) : (sub == 2'd3);
    if (size64)
      commit_val = hit ? {wdata, buf_q[1], buf_q[0]} : {wdata, cur[63:0]};
    else
      commit_val = hit ? {wdata[31:0], buf_q[2], buf_q[1], buf_q[0]}
                       : {wdata[31:0], cur[95:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) reg_q[i] <= '0;
      for (int j = 0; j < 3; j++) buf_q[j] <= '0;
      pend_q   <= 1'b0;
      tag_q    <= '0;
      shadow_q <= '0;
      err_q    <= 1'b0;
    end else begin
      if (wr && is_piece) begin
        if (size64) begin
          buf_q[0] <= wdata[31:0];
          buf_q[1] <= wdata[63:32];
        end else begin
          buf_q[sub] <= wdata[31:0];
        end
        if (!pend_q) begin
          pend_q <= 1'b1;
          tag_q  <= fi;
        end
      end else if (wr && is_commit) begin
        reg_q[fi] <= commit_val;
        pend_q    <= 1'b0;
        if (!hit) err_q <= 1'b1;
      end
      if (rd && sub == 2'd0) shadow_q <= cur;
    end
  end

  always_comb begin
    rdata = '0;
    if (sub == 2'd0)
      rdata = size64 ? cur[63:0] : {32'd0, cur[31:0]};
    else if (!size64) begin
      case (sub)
        2'd1:    rdata = {32'd0, shadow_q[63:32]};
        2'd2:    rdata = {32'd0, shadow_q[95:64]};
        default: rdata = {32'd0, shadow_q[127:96]};
      endcase
    end else if (sub == 2'd2)
      rdata = shadow_q[127:64];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*WIDE_W +: WIDE_W] = reg_q[g];
  end
  assign err_o = err_q;
endmodule

// File: rtl/wrc_table.sv
module wrc_table
  import wrc_pkg::*;
#(
  parameter int NTBL = 16,
  parameter int TW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic          size64,
  input  logic [TW-1:0] tidx,
  input  logic          half,
  input  logic [63:0]   wdata,
  output logic [63:0]   rdata,
  output logic          err_o
);
  logic [ENTRY_W-1:0] ent_q [NTBL];
  logic [DWORD_W-1:0] hold_q;
  logic               hpend_q;
  logic [TW-1:0]      htag_q;
  logic [ENTRY_W-1:0] tshadow_q;
  logic               err_q;
  logic [ENTRY_W-1:0] cur;
  logic               hit;

  assign cur = ent_q[tidx];
  assign hit = hpend_q && (htag_q == tidx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTBL; i++) ent_q[i] <= '0;
      hold_q    <= '0;
      hpend_q   <= 1'b0;
      htag_q    <= '0;
      tshadow_q <= '0;
      err_q     <= 1'b0;
    end else begin
      if (wr && !half) begin
        if (size64) ent_q[tidx] <= wdata;
        else begin
          hold_q <= wdata[31:0];
          if (!hpend_q) begin
            hpend_q <= 1'b1;
            htag_q  <= tidx;
          end
        end
      end else if (wr && half && !size64) begin
        ent_q[tidx] <= hit ? {wdata[31:0], hold_q} : {wdata[31:0], cur[31:0]};
        hpend_q     <= 1'b0;
        if (!hit) err_q <= 1'b1;
      end
      if (rd && !half) tshadow_q <= cur;
    end
  end

  always_comb begin
    rdata = '0;
    if (!half) rdata = size64 ? cur : {32'd0, cur[31:0]};
    else if (!size64) rdata = {32'd0, tshadow_q[63:32]};
  end

  assign err_o = err_q;
endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
  import wrc_pkg::*;
#(
  parameter int AW       = 20,
  parameter int NPAGE    = 2,
  parameter int NWREG    = 4,
  parameter int NTBL     = 16,
  parameter int TBL_BASE = 'h8000,
  parameter int DSLOT    = 'h10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic                          req_size64,
  input  logic [AW-1:0]                 req_addr,
  input  logic [63:0]                   req_wdata,
  output logic                          rsp_valid,
  output logic [63:0]                   rsp_data,
  output logic                          collect_err,
  output logic [NPAGE*NWREG*WIDE_W-1:0] wide_regs_o,
  output logic [NPAGE*NDIRECT*DWORD_W-1:0] dir_regs_o
);
  localparam int PGW   = (NPAGE > 1) ? $clog2(NPAGE) : 1;
  localparam int IW    = (NWREG > 1) ? $clog2(NWREG) : 1;
  localparam int TW    = (NTBL > 1) ? $clog2(NTBL) : 1;
  localparam int NFLAT = NPAGE * NWREG;
  localparam int FW    = (NFLAT > 1) ? $clog2(NFLAT) : 1;
  localparam int NDIR  = NPAGE * NDIRECT;
  localparam int DFW   = (NDIR > 1) ? $clog2(NDIR) : 1;

  tgt_e           tgt;
  logic [PGW-1:0] page;
  logic [IW-1:0]  widx;
  logic [1:0]     didx;
  logic [TW-1:0]  tidx;
  logic [1:0]     sub;

  wrc_decode #(
    .AW(AW), .NPAGE(NPAGE), .NWREG(NWREG), .NTBL(NTBL), .TBL_BASE(TBL_BASE),
    .DSLOT(DSLOT), .PGW(PGW), .IW(IW), .TW(TW)
  ) u_dec (
    .addr(req_addr), .tgt(tgt), .page(page), .widx(widx),
    .didx(didx), .tidx(tidx), .sub(sub)
  );

  logic          wr_req, rd_req;
  logic [FW-1:0] fi;
  logic [DFW-1:0] di;
  assign wr_req = req_valid && req_write;
  assign rd_req = req_valid && !req_write;
  assign fi = FW'(page) * FW'(NWREG) + FW'(widx);
  assign di = DFW'(page) * DFW'(NDIRECT) + DFW'(didx);

  logic [63:0] wide_rdata, tbl_rdata;
  logic        wide_err, tbl_err;

  wrc_wide_bank #(.NREG(NFLAT), .FW(FW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_req && tgt == TGT_WIDE), .rd(rd_req && tgt == TGT_WIDE),
    .size64(req_size64), .fi(fi), .sub(sub), .wdata(req_wdata),
    .regs_o(wide_regs_o), .rdata(wide_rdata), .err_o(wide_err)
  );

  wrc_table #(.NTBL(NTBL), .TW(TW)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_req && tgt == TGT_TABLE), .rd(rd_req && tgt == TGT_TABLE),
    .size64(req_size64), .tidx(tidx), .half(sub[0]), .wdata(req_wdata),
    .rdata(tbl_rdata), .err_o(tbl_err)
  );

  logic [DWORD_W-1:0] dreg_q [NDIR];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDIR; i++) dreg_q[i] <= '0;
    end else if (wr_req && tgt == TGT_DIRECT && !req_size64) begin
      dreg_q[di] <= req_wdata[31:0];
    end
  end
  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    assign dir_regs_o[g*DWORD_W +: DWORD_W] = dreg_q[g];
  end

  logic [63:0] rd_mux;
  always_comb begin
    case (tgt)
      TGT_WIDE:   rd_mux = wide_rdata;
      TGT_TABLE:  rd_mux = tbl_rdata;
      TGT_DIRECT: rd_mux = req_size64 ? 64'd0 : {32'd0, dreg_q[di]};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_data  <= rd_req ? rd_mux : '0;
    end
  end

  assign collect_err = wide_err | tbl_err;

  logic unused_bits;
  assign unused_bits = ^{req_addr[1:0], sub[1]};
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker #(
  parameter int AW    = 20,
  parameter int NPAGE = 2,
  parameter int NWREG = 4,
  parameter int DSLOT = 'h10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_write,
  input logic                     req_size64,
  input logic [AW-1:0]            req_addr,
  input logic                     rsp_valid,
  input logic                     collect_err,
  input logic [NPAGE*NWREG*128-1:0] wide_regs_o,
  input logic [NPAGE*3*32-1:0]    dir_regs_o
);
  logic in_pages, low_piece32, dir_wr;
  assign in_pages    = req_addr < AW'(NPAGE * 8192);
  assign low_piece32 = req_valid && req_write && !req_size64 && in_pages &&
                       (req_addr[12:4] < 9'(NWREG)) && (req_addr[3:2] != 2'd3);
  assign dir_wr      = req_valid && req_write && in_pages &&
                       (req_addr[12:4] >= 9'(DSLOT)) && (req_addr[12:4] < 9'(DSLOT + 3)) &&
                       (req_addr[3:2] == 2'd0);

  assert_rsp_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    collect_err |=> collect_err);

  assert_low_piece_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    low_piece32 |=> $stable(wide_regs_o));

  assert_direct_spares_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> $stable(wide_regs_o));

  assert_wide_change_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wide_regs_o) |-> $past(req_valid && req_write));

  assert_direct_change_needs_dword_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_regs_o) |-> $past(req_valid && req_write && !req_size64));
endmodule

bind wide_reg_collector wrc_checker #(
  .AW(AW), .NPAGE(NPAGE), .NWREG(NWREG), .DSLOT(DSLOT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size64(req_size64), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .collect_err(collect_err), .wide_regs_o(wide_regs_o), .dir_regs_o(dir_regs_o)
);

// File: tb/wide_reg_collector_tb_top.sv
module wide_reg_collector_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_size64 = 1'b0;
  logic [19:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, collect_err;
  logic [63:0] rsp_data;
  logic [1023:0] wide_regs_o;
  logic [191:0]  dir_regs_o;

  always #2 clk = ~clk;

  wide_reg_collector dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size64(req_size64), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .collect_err(collect_err),
    .wide_regs_o(wide_regs_o), .dir_regs_o(dir_regs_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [63:0] d, input bit s64);
    req_valid = 1'b1; req_write = 1'b1; req_size64 = s64; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, input bit s64, input logic [63:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_size64 = s64; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard on each response (R11)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R11: unexpected response %h expected none", rsp_data);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {64'd0, rsp_data}, {64'd0, e});
      end
    end
  end

  function automatic logic [127:0] wreg(input int f);
    return wide_regs_o[f*128 +: 128];
  endfunction

  initial begin
    #400000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1023:0] snap_w;
    logic [191:0]  snap_d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 err", {127'd0, collect_err}, 128'd0);
    check("R12 regs", {96'd0, wide_regs_o[31:0]}, 128'd0);
    rd(20'h00010, 1'b0, 64'd0, "R12 read reg1");

    // R1 dword collection on page0 reg1
    wr(20'h00010, 64'h11111111, 0);
    wr(20'h00014, 64'h22222222, 0);
    wr(20'h00018, 64'h33333333, 0);
    check("R1 before commit", wreg(1), 128'd0);
    wr(20'h0001C, 64'h44444444, 0);
    check("R1 commit", wreg(1), 128'h44444444_33333333_22222222_11111111);
    rd(20'h00010, 0, 64'h11111111, "R3 dw0");
    rd(20'h00014, 0, 64'h22222222, "R3 dw1");
    rd(20'h0001C, 0, 64'h44444444, "R3 dw3");
    // R9 other page separate
    rd(20'h02010, 0, 64'd0, "R9 page1 reg1");

    // R2 qword writes page1 reg2 (flat 6)
    wr(20'h02020, 64'hAAAA0000_BBBB0001, 1);
    check("R2 before commit", wreg(6), 128'd0);
    wr(20'h02028, 64'hCCCC0002_DDDD0003, 1);
    check("R2 commit", wreg(6), 128'hCCCC0002_DDDD0003_AAAA0000_BBBB0001);
    wr(20'h02024, 64'hFFFFFFFF_FFFFFFFF, 1);
    check("R2 odd qword ignored", wreg(6), 128'hCCCC0002_DDDD0003_AAAA0000_BBBB0001);
    rd(20'h02020, 1, 64'hAAAA0000_BBBB0001, "R2 read lo");
    rd(20'h02028, 1, 64'hCCCC0002_DDDD0003, "R2 read hi");

    // R3 shadow keeps old value across a newer commit
    rd(20'h00010, 0, 64'h11111111, "R3 snap");
    wr(20'h00010, 64'h55555555, 0);
    wr(20'h00014, 64'h66666666, 0);
    wr(20'h00018, 64'h77777777, 0);
    wr(20'h0001C, 64'h88888888, 0);
    rd(20'h00014, 0, 64'h22222222, "R3 old shadow");
    rd(20'h00010, 0, 64'h55555555, "R3 new live");
    rd(20'h00018, 0, 64'h77777777, "R3 new shadow");

    // R4 direct register
    wr(20'h00100, 64'hDEADBEEF, 0);
    check("R4 direct out", {96'd0, dir_regs_o[31:0]}, {96'd0, 32'hDEADBEEF});
    rd(20'h00100, 0, 64'hDEADBEEF, "R4 direct read");

    // R5 direct write in the middle of a collection
    wr(20'h00030, 64'h01010101, 0);
    wr(20'h00034, 64'h02020202, 0);
    wr(20'h02110, 64'hCAFEF00D, 0);
    check("R5 direct p1 d1", {96'd0, dir_regs_o[4*32 +: 32]}, {96'd0, 32'hCAFEF00D});
    wr(20'h00038, 64'h03030303, 0);
    wr(20'h0003C, 64'h04040404, 0);
    check("R5 commit intact", wreg(3), 128'h04040404_03030303_02020202_01010101);
    check("R5 no err", {127'd0, collect_err}, 128'd0);

    // R6 table writes
    wr(20'h08028, 64'h01234567_89ABCDEF, 1);
    rd(20'h08028, 1, 64'h01234567_89ABCDEF, "R6 qword entry");
    wr(20'h08038, 64'hAABBCCDD, 0);
    rd(20'h08038, 1, 64'd0, "R6 held not committed");
    wr(20'h0803C, 64'h11223344, 0);
    rd(20'h08038, 0, 64'hAABBCCDD, "R7 snap lo");
    rd(20'h0803C, 0, 64'h11223344, "R7 hi");
    // R7 table shadow survives a newer write
    wr(20'h08038, 64'hFFFF0000_FFFF1111, 1);
    rd(20'h0803C, 0, 64'h11223344, "R7 old shadow");
    rd(20'h08038, 1, 64'hFFFF0000_FFFF1111, "R7 new live");

    // R8 mismatched commit
    wr(20'h00000, 64'h99999999, 0);
    wr(20'h0202C, 64'h12345678, 0);
    check("R8 merge", wreg(6), 128'h12345678_DDDD0003_AAAA0000_BBBB0001);
    check("R8 other untouched", wreg(0), 128'd0);
    check("R8 err set", {127'd0, collect_err}, 128'd1);
    wr(20'h00030, 64'h1, 0);
    wr(20'h00034, 64'h2, 0);
    wr(20'h00038, 64'h3, 0);
    wr(20'h0003C, 64'h4, 0);
    check("R8 good commit", wreg(3), {32'h4, 32'h3, 32'h2, 32'h1});
    check("R8 err sticky", {127'd0, collect_err}, 128'd1);

    // R10 unmapped
    rd(20'h05000, 0, 64'd0, "R10 gap");
    rd(20'h00180, 1, 64'd0, "R10 slot");
    rd(20'h08080, 1, 64'd0, "R10 past table");
    snap_w = wide_regs_o; snap_d = dir_regs_o;
    wr(20'h05000, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    wr(20'h00184, 64'hFFFF_FFFF, 0);
    check("R10 wide unchanged", {127'd0, wide_regs_o == snap_w}, 128'd1);
    check("R10 dir unchanged", {127'd0, dir_regs_o == snap_d}, 128'd1);

    repeat (3) @(negedge clk);
    check("R11 all responses seen", 128'(exp_q.size()), 128'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule